// File: doc/BRIEF.md
# Nesting Priority Interrupt Arbiter

This block decides, every clock, whether the processor core should enter a new interrupt handler, and if so for which source. Each maskable source presents a pending bit and a programmable priority; a smaller priority number is more urgent. A separate non-maskable request outranks all of them and is never blocked by any enable. The block tracks the level of the handler currently running. It raises a one-cycle take pulse, with the source index, when a request should be entered now.

With nesting on, a strictly more urgent request interrupts the running handler. The interrupted level is saved on an internal stack and becomes current again when the nested handler signals completion. With nesting off, maskable requests wait until no handler is running. The core can clear the global enable, for example from inside a handler, to hold back every maskable request. Pending bits belong to the requesting logic: the block never clears them. A source left pending after its handler completes is simply taken again.

Top module: `irq_nest_arb`

## Requirements
- R1: After reset `take` is 0 and `run_level` reads the idle code, which is the number of priority levels plus one (9 with default parameters).
- R2: Among maskable sources whose pending bit is set, the winner has the smallest priority value. On equal values the lowest source index wins. The level code of maskable source priority p is p+1.
- R3: With `nest_en` = 1, a winner whose level code is strictly below `run_level` is taken. `take` goes high for one cycle after the clock edge that samples the request, and `take_src` and `run_level` update on that same edge.
- R4: A request whose level code is equal to or above `run_level` is never taken.
- R5: A `hdl_done` pulse while a handler runs returns `run_level` to the level that handler preempted, or to the idle code if it preempted nothing.
- R6: With `nest_en` = 0, a maskable request is taken only while `run_level` is idle.
- R7: With `gie` = 0, no maskable source is taken, whatever its pending bit or priority.
- R8: `nmi_req` uses level code 0. It is taken with `take_nmi` = 1 and `take_src` = 0 whenever `run_level` is above 0, regardless of `gie` and `nest_en`.
- R9: In a cycle where `hdl_done` is high, nothing is taken. `hdl_done` while idle has no effect on `run_level`.
- R10: Handlers can nest one level deeper than there are priority levels, counting the non-maskable one. Completions then restore every preempted level in reverse order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_pend | input | NUM_SRC | Pending bit per maskable source |
| irq_prio | input | NUM_SRC*PRIO_W | Priority per source, source i in bits [i*PRIO_W +: PRIO_W] |
| nest_en | input | 1 | 1 lets more urgent requests preempt a running handler |
| gie | input | 1 | Global enable for maskable sources |
| hdl_done | input | 1 | One-cycle strobe: the running handler has finished |
| nmi_req | input | 1 | Non-maskable request |
| take | output | 1 | One-cycle pulse: enter a handler now |
| take_src | output | IDX_W | Source index of the taken request (0 for non-maskable) |
| take_nmi | output | 1 | The taken request is the non-maskable one |
| run_level | output | LVL_W | Level code of the running handler (0 non-maskable, p+1 source, idle above all) |

## Verification
The hardest state to reach is a completely full preemption stack. Getting there needs every priority level to be entered in strictly rising urgency with nesting on, and then the non-maskable request on top, with no completion strobe in between. Random stimulus rarely builds such a chain. A directed sequence therefore sets up one source per level, raises them one at a time from least to most urgent, adds the non-maskable request, and then checks each restored level as the completions unwind it. Random cycles that mix enables, completions and priorities cover the rest, and a bench model predicts each take and level.

// File: rtl/irq_nest_arb_pkg.sv
// Package: shared constants and the per-cycle action type of the arbiter.
// Assumes: nothing; parameter-free.
package irq_nest_arb_pkg;

    // Level code reserved for the non-maskable request
    localparam int unsigned NMI_LEVEL = 0;

    // Action chosen by the arbiter on the coming clock edge
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_TAKE = 2'd1,
        ACT_POP  = 2'd2
    } arb_act_e;

endpackage

// File: rtl/irq_prio_select.sv
// Module: irq_prio_select
// Finds the most urgent request among the enabled maskable sources.
// Smaller priority number wins; ties go to the lowest index.
// Assumes: req_vec already gated by the global enable. Returns idle_lvl
// when nothing is requested, so a caller's "more urgent" compare fails.
module irq_prio_select #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned LVL_W   = 4,
    parameter int unsigned IDX_W   = 3,
    parameter int unsigned IDLE    = 9
) (
    input  logic [NUM_SRC-1:0]        req_vec,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic [LVL_W-1:0]          best_lvl,
    output logic [IDX_W-1:0]          best_id
);

    logic [LVL_W-1:0] cand;

    // Linear scan: strict compare keeps the lowest index on ties
    always_comb begin
        best_lvl = LVL_W'(IDLE);
        best_id  = '0;
        cand     = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            cand = LVL_W'(prio_flat[i*PRIO_W +: PRIO_W]) + LVL_W'(1);
            if (req_vec[i] && (cand < best_lvl)) begin
                best_lvl = cand;
                best_id  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_level_stack.sv
// Module: irq_level_stack
// LIFO of preempted handler levels. Push saves the level being
// interrupted; pop hands back the most recently saved one.
// Assumes: caller never pushes when full nor pops when empty; the
// nesting rule (strictly rising urgency) bounds depth to DEPTH.
module irq_level_stack #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] push_lvl,
    output logic [LVL_W-1:0] top_lvl,
    output logic             empty
);

    localparam int unsigned SP_W   = $clog2(DEPTH + 1);
    localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LVL_W-1:0] mem [DEPTH];
    logic [SP_W-1:0]  sp;
    logic [SP_W-1:0]  sp_m1;

    // Entry below the pointer is the top of stack
    always_comb begin
        sp_m1   = sp - SP_W'(1);
        top_lvl = mem[sp_m1[ADDR_W-1:0]];
        empty   = (sp == '0);
    end

    // Pointer and storage update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[sp[ADDR_W-1:0]] <= push_lvl;
            sp                  <= sp + SP_W'(1);
        end else if (pop) begin
            sp <= sp_m1;
        end
    end

    AST_STACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (sp < SP_W'(DEPTH)));                                  // R10
    AST_STACK_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);                                                // R5
    AST_STACK_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));                                                // R9

endmodule

// File: rtl/irq_nest_arb.sv
// Module: irq_nest_arb (top)
// Chooses whether the core enters a new handler. It tracks the running
// level, saves preempted levels on a stack and restores them on completion.
// Level codes: 0 non-maskable, p+1 for source priority p, NLEV+1 idle.
// Assumes: hdl_done pulses once per finished handler; pending bits are
// cleared by their owners, not here.
module irq_nest_arb
    import irq_nest_arb_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    parameter int unsigned LVL_W   = $clog2((1 << PRIO_W) + 2)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        irq_pend,
    input  logic [NUM_SRC*PRIO_W-1:0] irq_prio,
    input  logic                      nest_en,
    input  logic                      gie,
    input  logic                      hdl_done,
    input  logic                      nmi_req,
    output logic                      take,
    output logic [IDX_W-1:0]          take_src,
    output logic                      take_nmi,
    output logic [LVL_W-1:0]          run_level
);

    localparam int unsigned NLEV = 1 << PRIO_W;
    localparam int unsigned IDLE = NLEV + 1;
    localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'(IDLE);

    logic [NUM_SRC-1:0] gated_req;
    logic [LVL_W-1:0]   sel_lvl;
    logic [IDX_W-1:0]   sel_id;
    logic [LVL_W-1:0]   win_lvl;
    logic [IDX_W-1:0]   win_id;
    logic               win_nmi;
    logic               busy;
    logic               allowed;
    arb_act_e           act;
    logic               stk_push;
    logic               stk_pop;
    logic [LVL_W-1:0]   stk_top;
    logic               stk_empty;

    // Global enable masks every maskable source
    always_comb gated_req = gie ? irq_pend : '0;

    irq_prio_select #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .LVL_W   (LVL_W),
        .IDX_W   (IDX_W),
        .IDLE    (IDLE)
    ) u_select (
        .req_vec   (gated_req),
        .prio_flat (irq_prio),
        .best_lvl  (sel_lvl),
        .best_id   (sel_id)
    );

    // Non-maskable request overrides the maskable winner
    always_comb begin
        if (nmi_req) begin
            win_lvl = LVL_W'(NMI_LEVEL);
            win_id  = '0;
            win_nmi = 1'b1;
        end else begin
            win_lvl = sel_lvl;
            win_id  = sel_id;
            win_nmi = 1'b0;
        end
    end

    // Action for this edge: completion first, then preemption or entry
    always_comb begin
        busy    = (run_level != IDLE_LVL);
        allowed = win_nmi || nest_en || !busy;
        if (hdl_done) begin
            act = busy ? ACT_POP : ACT_HOLD;
        end else if ((win_lvl < run_level) && allowed) begin
            act = ACT_TAKE;
        end else begin
            act = ACT_HOLD;
        end
        stk_push = (act == ACT_TAKE) && busy;
        stk_pop  = (act == ACT_POP) && !stk_empty;
    end

    irq_level_stack #(
        .DEPTH (NLEV),
        .LVL_W (LVL_W)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (stk_push),
        .pop      (stk_pop),
        .push_lvl (run_level),
        .top_lvl  (stk_top),
        .empty    (stk_empty)
    );

    // Running level and take outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_level <= IDLE_LVL;
            take      <= 1'b0;
            take_src  <= '0;
            take_nmi  <= 1'b0;
        end else begin
            take <= 1'b0;
            case (act)
                ACT_TAKE: begin
                    run_level <= win_lvl;
                    take      <= 1'b1;
                    take_src  <= win_id;
                    take_nmi  <= win_nmi;
                end
                ACT_POP: begin
                    run_level <= stk_empty ? IDLE_LVL : stk_top;
                end
                default: begin
                end
            endcase
        end
    end

    AST_TAKE_RAISES_URGENCY: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (run_level < $past(run_level)));                       // R3
    AST_DONE_BLOCKS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_done |=> !take);                                            // R9
    AST_GIE_BLOCKS_MASKABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie && !nmi_req) |=> !take);                                  // R7
    AST_NO_NEST_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_en && !nmi_req && (run_level != IDLE_LVL)) |=> !take);   // R6
    AST_NMI_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_nmi) |-> (run_level == '0 && take_src == '0));    // R8
    AST_LEVEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_level <= IDLE_LVL);                                         // R1

endmodule

// File: tb/irq_nest_arb_tb.sv
module irq_nest_arb_tb;

    localparam int NUM_SRC = 8;
    localparam int PRIO_W  = 3;
    localparam int IDX_W   = 3;
    localparam int LVL_W   = 4;
    localparam int NLEV    = 8;
    localparam int IDLE    = NLEV + 1;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [NUM_SRC-1:0]        irq_pend = '0;
    logic [NUM_SRC*PRIO_W-1:0] irq_prio = '0;
    logic                      nest_en = 1'b1;
    logic                      gie = 1'b1;
    logic                      hdl_done = 1'b0;
    logic                      nmi_req = 1'b0;
    logic                      take;
    logic [IDX_W-1:0]          take_src;
    logic                      take_nmi;
    logic [LVL_W-1:0]          run_level;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Bench model state
    int m_lvl = IDLE;
    int m_stk [NLEV];
    int m_sp = 0;

    always #10 clk = ~clk;

    irq_nest_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_prio(irq_prio),
        .nest_en(nest_en), .gie(gie), .hdl_done(hdl_done), .nmi_req(nmi_req),
        .take(take), .take_src(take_src), .take_nmi(take_nmi), .run_level(run_level)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    task automatic set_prio(input int src, input int p);
        irq_prio[src*PRIO_W +: PRIO_W] = PRIO_W'(p);
    endtask

    // One cycle: predict from the requirements, clock, compare, advance model
    task automatic step(input string tag);
        int  wl, wid, nl;
        bit  wn, go;
        wl = IDLE; wid = 0; wn = 0;
        if (nmi_req) begin
            wl = 0; wn = 1;
        end else if (gie) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                int c;
                c = int'(irq_prio[i*PRIO_W +: PRIO_W]) + 1;
                if (irq_pend[i] && c < wl) begin wl = c; wid = i; end
            end
        end
        go = !hdl_done && (wl < m_lvl) && (wn || nest_en || m_lvl == IDLE);
        nl = m_lvl;
        if (hdl_done && m_lvl != IDLE) begin
            if (m_sp > 0) begin m_sp--; nl = m_stk[m_sp]; end
            else nl = IDLE;
        end else if (go) begin
            if (m_lvl != IDLE) begin m_stk[m_sp] = m_lvl; m_sp++; end
            nl = wl;
        end
        @(posedge clk); #1;
        chk(take == go, tag, "take", int'(take), int'(go));
        chk(int'(run_level) == nl, tag, "run_level", int'(run_level), nl);
        if (go) begin
            chk(take_nmi == wn, tag, "take_nmi", int'(take_nmi), int'(wn));
            chk(int'(take_src) == wid, tag, "take_src", int'(take_src), wid);
        end
        m_lvl = nl;
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NUM_SRC; i++) set_prio(i, 5);
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(take == 1'b0, "R1", "take", int'(take), 0);
        chk(int'(run_level) == IDLE, "R1", "run_level", int'(run_level), IDLE);
        rst_n = 1'b1;
        step("R1");

        // R2: lowest value wins, tie to lowest index
        set_prio(1, 4); set_prio(3, 2); set_prio(6, 2);
        irq_pend = 8'b0100_1010;
        step("R2");
        chk(int'(take_src) == 3, "R2", "tie index", int'(take_src), 3);
        irq_pend = 8'b0000_0000;
        // R4: equal priority does not preempt
        set_prio(5, 2); irq_pend = 8'b0010_0000;
        step("R4"); step("R4");
        // R3: strictly more urgent preempts
        set_prio(5, 1);
        step("R3");
        chk(int'(run_level) == 2, "R3", "nested level", int'(run_level), 2);
        irq_pend = '0;
        // R5: completion restores the preempted level, then idle
        hdl_done = 1'b1; step("R5");
        chk(int'(run_level) == 3, "R5", "resumed", int'(run_level), 3);
        step("R5");
        hdl_done = 1'b0;

        // R6: deferral with nesting off
        nest_en = 1'b0;
        set_prio(2, 6); irq_pend = 8'b0000_0100; step("R6");
        set_prio(0, 0); irq_pend = 8'b0000_0001; step("R6"); step("R6");
        hdl_done = 1'b1; step("R6");
        hdl_done = 1'b0; step("R6");
        chk(int'(take_src) == 0, "R6", "deferred src", int'(take_src), 0);
        irq_pend = '0; hdl_done = 1'b1; step("R6"); hdl_done = 1'b0;

        // R7: global enable off blocks maskable; R8: NMI still taken
        gie = 1'b0; irq_pend = 8'b1111_1111; step("R7"); step("R7");
        nmi_req = 1'b1; step("R8"); step("R8");
        nmi_req = 1'b0; irq_pend = '0;
        hdl_done = 1'b1; step("R8");
        gie = 1'b1;

        // R9: done in the same cycle as a request; done while idle
        step("R9");
        irq_pend = 8'b0000_0001; step("R9");
        nest_en = 1'b1;
        hdl_done = 1'b1; irq_pend = 8'b0000_0001; nmi_req = 1'b1; step("R9");
        nmi_req = 1'b0; irq_pend = '0; step("R9");
        hdl_done = 1'b0;

        // R10: full-depth nesting, then reverse unwinding
        for (int i = 0; i < NUM_SRC; i++) set_prio(i, 7 - i);
        for (int i = 0; i < NUM_SRC; i++) begin
            irq_pend = 8'(1 << i); step("R10");
        end
        irq_pend = '0; nmi_req = 1'b1; step("R10");
        chk(m_sp == NLEV, "R10", "depth", m_sp, NLEV);
        nmi_req = 1'b0; hdl_done = 1'b1;
        for (int i = 0; i <= NUM_SRC; i++) step("R10");
        hdl_done = 1'b0;
        chk(int'(run_level) == IDLE, "R10", "unwound", int'(run_level), IDLE);

        // Random mix covering R2 R3 R4 R5 R6 R7 R8 R9
        for (int n = 0; n < 3000; n++) begin
            irq_pend = NUM_SRC'($urandom & $urandom & $urandom);
            irq_prio = (NUM_SRC*PRIO_W)'($urandom);
            nest_en  = ($urandom % 4) != 0;
            gie      = ($urandom % 8) != 0;
            hdl_done = ($urandom % 4) == 0;
            nmi_req  = ($urandom % 16) == 0;
            step("R2 R3 R5 R8 mix");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule